// File: doc/BRIEF.md
# Network Interrupt Aggregator and I/O Register Block

This block sits on a small synchronous register bus inside a router-style I/O controller. Its core gathers per-port interrupt events from three module slots into two 16-bit status words and raises one combined interrupt line towards the processor. Status bits are active-low: a zero means the port has a pending event, and all-ones means the word is idle.

Each slot owns a fixed place in the status words. Slot 0 takes the low bits of the first word. Slots 1 and 2 share the second word, slot 1 at bit 0 and slot 2 at bit 4. Interrupt sources pulse a per-port strobe to raise or to drop their bit. Software reads both words over the bus, and reads a module-presence word built from two presence pins. It also keeps a mask word that is plain storage. A serial configuration memory is driven by writing chip-select, clock and data-in levels to one register. The same register returns the memory's data-out line on reads.

Top module: `ioctl_regblk`

## Requirements
- R1: During and after synchronous reset, both status words are 0xFFFF, `net_irq` is 0, `bus_rdata` is 0, the mask word is 0 and the three memory pins are 0.
- R2: A raise strobe on `irq_set[s*PORTS_PER_SLOT+p]` clears status bit (base(s)+p) of slot s's word at the next edge. A drop strobe on `irq_clr` at the same index sets that bit back to 1. Other bits keep their value.
- R3: Slot-to-word map: slot 0 goes to word 0 with base 0, slot 1 to word 1 with base 0, and slot 2 to word 1 with base 4.
- R4: When raise and drop strobes hit the same bit in the same cycle, the bit becomes 0.
- R5: `net_irq` is registered. At each edge it takes 1 if either status word differed from 0xFFFF just before that edge, and 0 otherwise. It therefore lags a status change by one clock.
- R6: Word 0 reads at offset 0x26 and word 1 at offset 0x28. Bus writes to these offsets change nothing.
- R7: The mask word at offset 0x30 returns the last 16-bit value written. It has no effect on `net_irq`.
- R8: Offset 0x20 reads 0xFFFF with bit 3 cleared while `mod_present[0]` (slot 1) is high, and bit 11 cleared while `mod_present[1]` (slot 2) is high.
- R9: A write to offset 0x0E loads `ee_cs` from data bit 0, `ee_sk` from bit 1 and `ee_di` from bit 2. The pins hold until the next write to 0x0E. A read of 0x0E returns the pins in bits 2:0, `ee_do` in bit 3, and zero elsewhere.
- R10: `bus_rdata` is loaded at the edge where `bus_rd_en` is high, with the addressed value as it stood before that edge. It holds while `bus_rd_en` is low. Any offset not listed above reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_set | input | 3*PORTS_PER_SLOT | Per slot/port raise strobes, index slot*PORTS_PER_SLOT+port |
| irq_clr | input | 3*PORTS_PER_SLOT | Per slot/port drop strobes, same indexing |
| mod_present | input | 2 | Module present in slot 1 (bit 0) and slot 2 (bit 1) |
| ee_do | input | 1 | Data-out from the serial memory |
| ee_cs | output | 1 | Serial memory chip select |
| ee_sk | output | 1 | Serial memory clock |
| ee_di | output | 1 | Serial memory data-in |
| net_irq | output | 1 | Combined network interrupt, active high |

## Verification
The bench targets the slot map. A wrong base or word for slot 2 would show its ports in slot 1's nibble or in word 0. It also drives a raise and a drop on the same bit in one cycle, where a design that gives priority to the drop would leave the bit idle. It times `net_irq` to the exact edge, so a combinational or two-stage path fails, and it shows that mask writes leave the line alone. Writes to the status offsets, unmapped reads, and memory pins that must hold across unrelated writes round out the directed cases. A long random phase then compares every output against a behavioural model on every clock.

// File: rtl/ioctl_pkg.sv
package ioctl_pkg;
  localparam int DW        = 16;
  localparam int SLOTS     = 3;
  localparam int STAT_REGS = 2;

  localparam logic [7:0] OFS_EEPROM  = 8'h0E;
  localparam logic [7:0] OFS_PRESENT = 8'h20;
  localparam logic [7:0] OFS_NSTAT0  = 8'h26;
  localparam logic [7:0] OFS_NSTAT1  = 8'h28;
  localparam logic [7:0] OFS_MASK    = 8'h30;

  localparam int PRES_BIT_S1 = 3;
  localparam int PRES_BIT_S2 = 11;
  localparam int EE_DO_BIT   = 3;

  // serial memory pin levels, bit 0 = chip select, 1 = clock, 2 = data-in
  typedef struct packed {
    logic di;
    logic sk;
    logic cs;
  } ee_pins_t;

  // which status word a slot lands in
  function automatic int slot_word(input int s);
    return (s == 0) ? 0 : 1;
  endfunction

  // first bit of a slot inside its word
  function automatic int slot_base(input int s);
    return (s == 2) ? 4 : 0;
  endfunction
endpackage

// File: rtl/netirq_agg.sv
module netirq_agg
  import ioctl_pkg::*;
#(
  parameter int PORTS = 4,
  localparam int NSTROBE = SLOTS * PORTS
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [NSTROBE-1:0]                 set_i,
  input  logic [NSTROBE-1:0]                 clr_i,
  output logic [STAT_REGS-1:0][DW-1:0]       stat_o,
  output logic                               pend_o
);
  logic [STAT_REGS-1:0][DW-1:0] set_m, clr_m, stat_q, stat_d;
  logic                         pend_q;

  always_comb begin
    set_m = '0;
    clr_m = '0;
    for (int s = 0; s < SLOTS; s++) begin
      for (int p = 0; p < PORTS; p++) begin
        set_m[slot_word(s)][slot_base(s) + p] = set_i[s*PORTS + p];
        clr_m[slot_word(s)][slot_base(s) + p] = clr_i[s*PORTS + p];
      end
    end
  end

  // drop first, raise last: a raise on the same bit wins
  always_comb begin
    for (int w = 0; w < STAT_REGS; w++)
      stat_d[w] = (stat_q[w] | clr_m[w]) & ~set_m[w];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '1;
      pend_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      pend_q <= ~&stat_q;
    end
  end

  assign stat_o = stat_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/ee_port.sv
module ee_port
  import ioctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wr_i,
  input  logic [2:0] din_i,
  output ee_pins_t pins_o
);
  ee_pins_t pins_q;

  always_ff @(posedge clk) begin
    if (rst)       pins_q <= '0;
    else if (wr_i) pins_q <= ee_pins_t'(din_i);
  end

  assign pins_o = pins_q;
endmodule

// File: rtl/reg_rdmux.sv
module reg_rdmux
  import ioctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rd_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [STAT_REGS-1:0][DW-1:0] stat_i,
  input  logic [DW-1:0]                mask_i,
  input  logic [1:0]                   present_i,
  input  ee_pins_t                     pins_i,
  input  logic                         ee_do_i,
  output logic [DW-1:0]                rdata_o
);
  logic [DW-1:0] pres_w, ee_w, word_d, rdata_q;

  always_comb begin
    pres_w = '1;
    if (present_i[0]) pres_w[PRES_BIT_S1] = 1'b0;
    if (present_i[1]) pres_w[PRES_BIT_S2] = 1'b0;
    ee_w            = '0;
    ee_w[2:0]       = pins_i;
    ee_w[EE_DO_BIT] = ee_do_i;
  end

  always_comb begin
    case (addr_i)
      ADDR_W'(OFS_EEPROM):  word_d = ee_w;
      ADDR_W'(OFS_PRESENT): word_d = pres_w;
      ADDR_W'(OFS_NSTAT0):  word_d = stat_i[0];
      ADDR_W'(OFS_NSTAT1):  word_d = stat_i[1];
      ADDR_W'(OFS_MASK):    word_d = mask_i;
      default:              word_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (rd_i) rdata_q <= word_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/ioctl_regblk.sv
module ioctl_regblk
  import ioctl_pkg::*;
#(
  parameter int PORTS_PER_SLOT = 4,
  parameter int ADDR_W         = 8,
  localparam int NSTROBE       = SLOTS * PORTS_PER_SLOT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr_en,
  input  logic               bus_rd_en,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [15:0]        bus_wdata,
  output logic [15:0]        bus_rdata,
  input  logic [NSTROBE-1:0] irq_set,
  input  logic [NSTROBE-1:0] irq_clr,
  input  logic [1:0]         mod_present,
  input  logic               ee_do,
  output logic               ee_cs,
  output logic               ee_sk,
  output logic               ee_di,
  output logic               net_irq
);
  logic [STAT_REGS-1:0][DW-1:0] stat;
  logic [DW-1:0]                mask_q;
  ee_pins_t                     pins;
  logic                         wr_mask, wr_ee;

  assign wr_mask = bus_wr_en && (bus_addr == ADDR_W'(OFS_MASK));
  assign wr_ee   = bus_wr_en && (bus_addr == ADDR_W'(OFS_EEPROM));

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (wr_mask) mask_q <= bus_wdata;
  end

  netirq_agg #(.PORTS(PORTS_PER_SLOT)) u_agg (
    .clk    (clk),
    .rst    (rst),
    .set_i  (irq_set),
    .clr_i  (irq_clr),
    .stat_o (stat),
    .pend_o (net_irq)
  );

  ee_port u_ee (
    .clk    (clk),
    .rst    (rst),
    .wr_i   (wr_ee),
    .din_i  (bus_wdata[2:0]),
    .pins_o (pins)
  );

  reg_rdmux #(.ADDR_W(ADDR_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_i      (bus_rd_en),
    .addr_i    (bus_addr),
    .stat_i    (stat),
    .mask_i    (mask_q),
    .present_i (mod_present),
    .pins_i    (pins),
    .ee_do_i   (ee_do),
    .rdata_o   (bus_rdata)
  );

  assign ee_cs = pins.cs;
  assign ee_sk = pins.sk;
  assign ee_di = pins.di;
endmodule

// File: rtl/ioctl_regblk_chk.sv
module ioctl_regblk_chk
  import ioctl_pkg::*;
#(
  parameter int PORTS  = 4,
  parameter int ADDR_W = 8,
  localparam int NSTROBE = SLOTS * PORTS
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    bus_wr_en,
  input logic                    bus_rd_en,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [15:0]             bus_wdata,
  input logic [15:0]             bus_rdata,
  input logic [NSTROBE-1:0]      irq_set,
  input logic [NSTROBE-1:0]      irq_clr,
  input logic                    ee_cs,
  input logic                    ee_sk,
  input logic                    ee_di,
  input logic                    net_irq,
  input logic [STAT_REGS*DW-1:0] stat_flat,
  input logic [DW-1:0]           mask_q
);
  logic known;
  assign known = (bus_addr == ADDR_W'(OFS_EEPROM))  || (bus_addr == ADDR_W'(OFS_PRESENT)) ||
                 (bus_addr == ADDR_W'(OFS_NSTAT0))  || (bus_addr == ADDR_W'(OFS_NSTAT1))  ||
                 (bus_addr == ADDR_W'(OFS_MASK));

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    for (genvar p = 0; p < PORTS; p++) begin : g_port
      localparam int IX = s*PORTS + p;
      localparam int BI = slot_word(s)*DW + slot_base(s) + p;
      a_r2_set_clears: assert property (@(posedge clk) disable iff (rst)
        irq_set[IX] |=> !stat_flat[BI]);
      a_r2_clr_sets: assert property (@(posedge clk) disable iff (rst)
        (irq_clr[IX] && !irq_set[IX]) |=> stat_flat[BI]);
      a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
        (irq_clr[IX] && irq_set[IX]) |=> !stat_flat[BI]);
    end
  end

  a_r5_irq_up: assert property (@(posedge clk) disable iff (rst)
    (stat_flat != '1) |=> net_irq);
  a_r5_irq_down: assert property (@(posedge clk) disable iff (rst)
    (stat_flat == '1) |=> !net_irq);
  a_r6_wr_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && (bus_addr == ADDR_W'(OFS_NSTAT0) || bus_addr == ADDR_W'(OFS_NSTAT1))
     && irq_set == '0 && irq_clr == '0) |=> $stable(stat_flat));
  a_r7_mask_store: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && bus_addr == ADDR_W'(OFS_MASK)) |=> mask_q == $past(bus_wdata));
  a_r9_pins_load: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && bus_addr == ADDR_W'(OFS_EEPROM)) |=> {ee_di, ee_sk, ee_cs} == $past(bus_wdata[2:0]));
  a_r9_pins_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr_en && bus_addr == ADDR_W'(OFS_EEPROM)) |=> $stable({ee_di, ee_sk, ee_cs}));
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && !known) |=> bus_rdata == 16'h0000);
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_en |=> $stable(bus_rdata));
endmodule

bind ioctl_regblk ioctl_regblk_chk #(.PORTS(PORTS_PER_SLOT), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr_en (bus_wr_en),
  .bus_rd_en (bus_rd_en),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_set   (irq_set),
  .irq_clr   (irq_clr),
  .ee_cs     (ee_cs),
  .ee_sk     (ee_sk),
  .ee_di     (ee_di),
  .net_irq   (net_irq),
  .stat_flat (stat),
  .mask_q    (mask_q)
);

// File: tb/ioctl_regblk_test.sv
`timescale 1ns/1ps
module ioctl_regblk_test;
  localparam int P  = 4;
  localparam int NS = 3 * P;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [NS-1:0] irq_set = '0, irq_clr = '0;
  logic [1:0] mod_present = '0;
  logic ee_do = 1'b0;
  logic ee_cs, ee_sk, ee_di, net_irq;

  always #4 clk = ~clk;

  ioctl_regblk #(.PORTS_PER_SLOT(P), .ADDR_W(8)) uut (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_set(irq_set), .irq_clr(irq_clr), .mod_present(mod_present),
    .ee_do(ee_do), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .net_irq(net_irq)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit started = 0, done = 0;

  // behavioural reference model
  logic [15:0] m_st [2];
  logic [15:0] m_mask, m_rdata;
  logic [2:0]  m_pins;
  logic        m_irq;
  string       m_tag = "R1";

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    started = 1;
    if (rst) begin
      m_st[0] = 16'hFFFF; m_st[1] = 16'hFFFF;
      m_mask = 0; m_rdata = 0; m_pins = 0; m_irq = 0; m_tag = "R1";
    end else begin
      if (bus_rd_en) begin
        case (bus_addr)
          8'h0E: begin m_rdata = {12'h000, ee_do, m_pins}; m_tag = "R9"; end
          8'h20: begin
            m_rdata = 16'hFFFF;
            if (mod_present[0]) m_rdata[3]  = 1'b0;
            if (mod_present[1]) m_rdata[11] = 1'b0;
            m_tag = "R8";
          end
          8'h26: begin m_rdata = m_st[0]; m_tag = "R6"; end
          8'h28: begin m_rdata = m_st[1]; m_tag = "R6"; end
          8'h30: begin m_rdata = m_mask;  m_tag = "R7"; end
          default: begin m_rdata = 16'h0000; m_tag = "R10"; end
        endcase
      end
      m_irq = (m_st[0] != 16'hFFFF) || (m_st[1] != 16'hFFFF);
      for (int s = 0; s < 3; s++) begin
        for (int p = 0; p < P; p++) begin
          int w, b;
          w = (s == 0) ? 0 : 1;
          b = ((s == 2) ? 4 : 0) + p;
          if (irq_set[s*P+p])      m_st[w][b] = 1'b0;
          else if (irq_clr[s*P+p]) m_st[w][b] = 1'b1;
        end
      end
      if (bus_wr_en && bus_addr == 8'h30) m_mask = bus_wdata;
      if (bus_wr_en && bus_addr == 8'h0E) m_pins = bus_wdata[2:0];
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      check(m_tag, bus_rdata, m_rdata);
      check("R5", {15'h0, net_irq}, {15'h0, m_irq});
      check("R9", {13'h0, ee_di, ee_sk, ee_cs}, {13'h0, m_pins});
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rd(logic [7:0] a, string tag, logic [15:0] exp);
    bus_rd_en = 1; bus_addr = a;
    tick();
    check(tag, bus_rdata, exp);
    bus_rd_en = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    bus_wr_en = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr_en = 0;
  endtask

  task automatic pulse(logic [NS-1:0] st, logic [NS-1:0] cl);
    irq_set = st; irq_clr = cl;
    tick();
    irq_set = '0; irq_clr = '0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) tick();
    // R1: reset state
    check("R1", bus_rdata, 16'h0000);
    check("R1", {15'h0, net_irq}, 16'h0000);
    check("R1", {13'h0, ee_di, ee_sk, ee_cs}, 16'h0000);
    rst = 0;
    tick();
    rd(8'h26, "R1", 16'hFFFF);
    rd(8'h28, "R1", 16'hFFFF);
    rd(8'h30, "R1", 16'h0000);

    // R10: sweep offsets
    for (int a = 0; a < 8'h50; a += 2) begin
      bus_rd_en = 1; bus_addr = 8'(a);
      tick();
    end
    bus_rd_en = 0;
    rd(8'h40, "R10", 16'h0000);
    rd(8'h27, "R10", 16'h0000);
    // R10: hold while no read
    tick(); tick();
    check("R10", bus_rdata, 16'h0000);

    // R7: mask storage, no effect on interrupt line
    wr(8'h30, 16'hA5C3);
    rd(8'h30, "R7", 16'hA5C3);
    tick();
    check("R7", {15'h0, net_irq}, 16'h0000);
    wr(8'h30, 16'h0000);
    rd(8'h30, "R7", 16'h0000);

    // R8: presence
    mod_present = 2'b01; rd(8'h20, "R8", 16'hFFF7);
    mod_present = 2'b10; rd(8'h20, "R8", 16'hF7FF);
    mod_present = 2'b11; rd(8'h20, "R8", 16'hF7F7);
    mod_present = 2'b00; rd(8'h20, "R8", 16'hFFFF);

    // R9: serial memory pins
    wr(8'h0E, 16'h0005);
    check("R9", {13'h0, ee_di, ee_sk, ee_cs}, 16'h0005);
    ee_do = 1; rd(8'h0E, "R9", 16'h000D);
    wr(8'h0E, 16'hFFF2);
    ee_do = 0; rd(8'h0E, "R9", 16'h0002);
    wr(8'h30, 16'h0007);
    wr(8'h26, 16'h0007);
    tick();
    check("R9", {13'h0, ee_di, ee_sk, ee_cs}, 16'h0002);

    // R2 and R5 timing: slot 0 port 2
    pulse(NS'(1) << 2, '0);
    check("R5", {15'h0, net_irq}, 16'h0000);
    tick();
    check("R5", {15'h0, net_irq}, 16'h0001);
    rd(8'h26, "R2", 16'hFFFB);
    rd(8'h28, "R2", 16'hFFFF);
    // R6: write to status ignored
    wr(8'h26, 16'h0000);
    wr(8'h28, 16'h0000);
    rd(8'h26, "R6", 16'hFFFB);
    rd(8'h28, "R6", 16'hFFFF);
    // R2: drop
    pulse('0, NS'(1) << 2);
    rd(8'h26, "R2", 16'hFFFF);
    tick();
    check("R5", {15'h0, net_irq}, 16'h0000);

    // R3: slot 2 port 1 -> word 1 bit 5; slot 1 port 3 -> word 1 bit 3
    pulse(NS'(1) << (2*P + 1), '0);
    rd(8'h28, "R3", 16'hFFDF);
    pulse(NS'(1) << (1*P + 3), '0);
    rd(8'h28, "R3", 16'hFFD7);
    rd(8'h26, "R3", 16'hFFFF);
    pulse('0, '1);
    rd(8'h28, "R3", 16'hFFFF);

    // R4: raise and drop on the same bit together
    pulse(NS'(1) << P, NS'(1) << P);
    rd(8'h28, "R4", 16'hFFFE);
    pulse('0, '1);
    rd(8'h28, "R4", 16'hFFFF);

    // random phase, model compares every clock
    for (int i = 0; i < 4000; i++) begin
      int k;
      k = $urandom_range(0, 7);
      irq_set = ($urandom_range(0, 3) == 0) ? NS'($urandom & $urandom) : '0;
      irq_clr = ($urandom_range(0, 2) == 0) ? NS'($urandom | $urandom) : '0;
      mod_present = 2'($urandom);
      ee_do = 1'($urandom);
      bus_rd_en = 1'($urandom);
      bus_wr_en = ($urandom_range(0, 3) == 0);
      case (k)
        0: bus_addr = 8'h0E; 1: bus_addr = 8'h20; 2: bus_addr = 8'h26;
        3: bus_addr = 8'h28; 4: bus_addr = 8'h30; 5: bus_addr = 8'h0E;
        6: bus_addr = 8'h30; default: bus_addr = 8'($urandom);
      endcase
      bus_wdata = 16'($urandom);
      tick();
    end
    bus_rd_en = 0; bus_wr_en = 0; irq_set = '0; irq_clr = '0;
    tick();
    finish_run();
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R10: actual hung expected finished");
      finish_run();
    end
  end
endmodule